// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming Ethernet frame is kept. It looks only at the frame's 48-bit destination address. The address arrives as a stream of bytes, and a strobe marks the first byte. The block matches the address against the station address and recognises the all-ones broadcast address. It also classifies group (multicast) addresses through a 64-entry hash table.

The multicast hash is a CRC-32 over the six address bytes. The CRC uses polynomial 0x04C11DB7, shifts MSB-first, starts from all ones and takes each byte least significant bit first. The six most significant CRC bits pick one bit of the table.

A 4-bit receive-configuration input says which match classes are accepted: everything, station match, multicast and broadcast. One cycle after the last address byte, the block presents an accept decision and the three match-type flags. They stay there until the next frame starts. A build parameter selects a second table layout. In that layout the two 32-bit hash words are exchanged and each word is byte-reversed.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, result_valid, accept, phys_match, bcast_match and mcast_match are all 0.
- R2: A byte with in_valid and in_first high starts a new address. The next five in_valid bytes complete it, and byte k (k = 0..5) is address bits [8k+7:8k]. result_valid rises in the cycle after the sixth byte and holds until the next in_first. Further bytes do not change the result, and valid bytes before any in_first are ignored. While result_valid is 0, all four decision outputs are 0.
- R3: phys_match is 1 when the address equals station_addr, where byte k of the stream is compared with station_addr[8k+7:8k]. rx_cfg bit 1 accepts such frames.
- R4: An all-ones address sets bcast_match and never sets mcast_match. rx_cfg bit 3 accepts it.
- R5: An address is a group address when bit 0 of its first byte is 1. For a group address that is not broadcast, mcast_match is 1 exactly when the hash bit selected by CRC bits [31:26] is 1. rx_cfg bit 2 accepts such frames.
- R6: With SWAP_HASH=0, hash bit i is bit i of {hash_hi, hash_lo}. With SWAP_HASH=1, the 64-bit table is {byte-reversed hash_lo, byte-reversed hash_hi}.
- R7: rx_cfg bit 0 accepts every completed address, whatever its class.
- R8: The match flags are reported whatever rx_cfg holds. A frame whose class has no enabling rx_cfg bit is rejected, and rx_cfg = 0 rejects everything.
- R9: An in_first byte in the middle of an address, or after a result, restarts collection and clears result_valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_byte carries an address byte |
| in_first | input | 1 | Marks the first byte of an address |
| in_byte | input | 8 | Address byte |
| station_addr | input | 48 | Station address, first byte in bits [7:0] |
| hash_lo | input | 32 | Hash table word at the lower position |
| hash_hi | input | 32 | Hash table word at the upper position |
| rx_cfg | input | 4 | Accept enables: 0 all, 1 station, 2 multicast, 3 broadcast |
| result_valid | output | 1 | Decision outputs are valid |
| accept | output | 1 | Frame is accepted |
| phys_match | output | 1 | Address equals the station address |
| bcast_match | output | 1 | Address is broadcast |
| mcast_match | output | 1 | Group address whose hash bit is set |

## Verification
Two faults matter most, and both show on the decision outputs in the cycle after the sixth byte. A wrong CRC state or a mis-indexed table word moves the selected hash bit, so mcast_match flips for a chosen address with a single-bit table. A byte counter that is off by one either raises result_valid a cycle too early or too late, or lets trailing bytes corrupt the stored address. The bench catches the counter fault by sampling exactly one cycle after the last byte and again after extra bytes. The swapped-layout instance is driven with the rearranged words, so its flags must match the plain instance.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter bit          SWAP_HASH  = 1'b0,
  parameter int          ADDR_BYTES = 6,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_first,
  input  logic [7:0]              in_byte,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [31:0]             hash_lo,
  input  logic [31:0]             hash_hi,
  input  logic [3:0]              rx_cfg,
  output logic                    result_valid,
  output logic                    accept,
  output logic                    phys_match,
  output logic                    bcast_match,
  output logic                    mcast_match
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ b[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  logic [ADDR_W-1:0] da_q;
  logic [31:0]       crc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic [63:0]       table_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      da_q   <= '0;
      crc_q  <= '1;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (in_valid) begin
      if (in_first) begin
        da_q   <= ADDR_W'(in_byte);
        crc_q  <= crc_step(32'hFFFF_FFFF, in_byte);
        cnt_q  <= CNT_W'(1);
        done_q <= (ADDR_BYTES == 1);
      end else if (cnt_q != '0 && !done_q) begin
        da_q[8*cnt_q +: 8] <= in_byte;
        crc_q  <= crc_step(crc_q, in_byte);
        cnt_q  <= cnt_q + CNT_W'(1);
        done_q <= (cnt_q == CNT_W'(ADDR_BYTES - 1));
      end
    end
  end

  generate
    if (SWAP_HASH) begin : g_swapped
      assign table_w = {bswap(hash_lo), bswap(hash_hi)};
    end else begin : g_plain
      assign table_w = {hash_hi, hash_lo};
    end
  endgenerate

  wire is_bc  = &da_q;
  wire is_grp = da_q[0] & ~is_bc;
  wire hit    = table_w[crc_q[31:26]];

  assign result_valid = done_q;
  assign phys_match   = done_q & (da_q == station_addr);
  assign bcast_match  = done_q & is_bc;
  assign mcast_match  = done_q & is_grp & hit;
  assign accept       = done_q & (rx_cfg[0] | (rx_cfg[1] & phys_match) |
                                  (rx_cfg[2] & mcast_match) | (rx_cfg[3] & bcast_match));
endmodule

module rx_addr_filter_chk #(
  parameter int ADDR_BYTES = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_first,
  input logic [3:0] rx_cfg,
  input logic       result_valid,
  input logic       accept,
  input logic       phys_match,
  input logic       bcast_match,
  input logic       mcast_match
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else if (in_valid && in_first) bcnt <= CW'(1);
    else if (in_valid && bcnt != '0 && bcnt < CW'(ADDR_BYTES)) bcnt <= bcnt + CW'(1);
  end

  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> !accept && !phys_match && !bcast_match && !mcast_match); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_first && bcnt == CW'(ADDR_BYTES - 1) |=> result_valid); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && !(in_valid && in_first) |=> result_valid); // R2
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_first |=> !result_valid); // R9
  AST_BCAST_NOT_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_match |-> !mcast_match); // R4
  AST_PHYS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cfg[1] && phys_match |-> accept); // R3
  AST_MCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cfg[2] && mcast_match |-> accept); // R5
  AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && rx_cfg[0] |-> accept); // R7
  AST_NO_ENABLE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cfg == 4'd0 |-> !accept); // R8
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.ADDR_BYTES(ADDR_BYTES)) chk_i (.*);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [47:0] station_addr = 48'h5544_3322_1102;
  logic [31:0] hash_lo = '0, hash_hi = '0, sw_lo = '0, sw_hi = '0;
  logic [3:0]  rx_cfg = '0;
  logic [63:0] tbl = '0;
  logic [4:0]  o_a, o_b;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_addr_filter dut_i (.clk, .rst_n, .in_valid, .in_first, .in_byte, .station_addr,
    .hash_lo, .hash_hi, .rx_cfg, .result_valid(o_a[4]), .accept(o_a[3]),
    .phys_match(o_a[2]), .bcast_match(o_a[1]), .mcast_match(o_a[0]));
  rx_addr_filter #(.SWAP_HASH(1'b1)) dut_sw_i (.clk, .rst_n, .in_valid, .in_first, .in_byte,
    .station_addr, .hash_lo(sw_lo), .hash_hi(sw_hi), .rx_cfg, .result_valid(o_b[4]),
    .accept(o_b[3]), .phys_match(o_b[2]), .bcast_match(o_b[1]), .mcast_match(o_b[0]));

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[31] ^ a[8*k+i];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c[31:26];
  endfunction

  // expected {valid, accept, phys, bcast, mcast}
  function automatic logic [4:0] expect_out(input logic [47:0] a);
    logic ph = (a == station_addr);
    logic bc = (a == '1);
    logic mc = a[0] && !bc && tbl[hidx(a)];
    logic ac = rx_cfg[0] | (rx_cfg[1] & ph) | (rx_cfg[2] & mc) | (rx_cfg[3] & bc);
    return {1'b1, ac, ph, bc, mc};
  endfunction

  task automatic set_table(input logic [63:0] t);
    tbl = t;
    hash_lo = t[31:0];  hash_hi = t[63:32];
    sw_lo = bsw(t[63:32]); sw_hi = bsw(t[31:0]);
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    n_chk++;
    if (o_a !== exp) begin
      n_fail++;
      $display("FAIL %s plain: got %b expected %b", req, o_a, exp);
    end
    if (o_b !== exp) begin
      n_fail++;
      $display("FAIL %s swapped: got %b expected %b", req, o_b, exp);
    end
  endtask

  task automatic send(input logic [47:0] a, input int nb);
    for (int k = 0; k < nb; k++) begin
      in_valid = 1'b1; in_first = (k == 0); in_byte = a[8*k +: 8];
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset", 5'b00000);
  endtask

  task automatic t_unicast;
    rx_cfg = 4'b0010;
    send(station_addr, 6);
    chk("R2 R3 station match accepted", expect_out(station_addr));
    rx_cfg = 4'b1100;
    @(negedge clk);
    chk("R8 station flag without enable", 5'b10100);
    rx_cfg = 4'b0010;
    send(48'h5544_3322_1112, 6);
    chk("R3 other unicast rejected", 5'b10000);
  endtask

  task automatic t_broadcast;
    set_table('1);
    rx_cfg = 4'b1000;
    send('1, 6);
    chk("R4 broadcast accepted", 5'b11010);
    rx_cfg = 4'b0100;
    @(negedge clk);
    chk("R4 broadcast not multicast", 5'b10010);
  endtask

  task automatic t_multicast;
    logic [47:0] m = 48'h0100_005E_0001;
    logic [47:0] m2 = 48'h2211_00CC_BB33;
    logic [5:0] ix = hidx(m);
    rx_cfg = 4'b0100;
    set_table(64'd1 << ix);
    send(m, 6);
    chk("R5 R6 multicast hash hit", 5'b11001);
    set_table(~(64'd1 << ix));
    @(negedge clk);
    chk("R5 R6 multicast hash miss", 5'b10000);
    set_table(64'd1 << hidx(m2));
    send(m2, 6);
    chk("R5 R6 second group address hit", 5'b11001);
    rx_cfg = 4'b1010;
    @(negedge clk);
    chk("R8 multicast flag without enable", 5'b10001);
  endtask

  task automatic t_promisc;
    rx_cfg = 4'b0001;
    set_table('0);
    send(48'h0A0B_0C0D_0E10, 6);
    chk("R7 promiscuous unicast", 5'b11000);
    send(48'h0A0B_0C0D_0E11, 6);
    chk("R7 promiscuous group miss", 5'b11000);
  endtask

  task automatic t_zero_cfg;
    rx_cfg = 4'b0000;
    set_table('1);
    send('1, 6);
    chk("R8 cfg zero rejects broadcast", 5'b10010);
    send(station_addr, 6);
    chk("R8 cfg zero rejects station", 5'b10100);
  endtask

  task automatic t_stream;
    rx_cfg = 4'b0010;
    send(station_addr, 5);
    chk("R2 not valid after five bytes", 5'b00000);
    in_valid = 1'b1; in_byte = station_addr[47:40];
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 valid one cycle after sixth byte", 5'b11100);
    in_valid = 1'b1; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 trailing bytes ignored and result held", 5'b11100);
  endtask

  task automatic t_restart;
    rx_cfg = 4'b0010;
    send(48'hFFFF_FFFF_FFFF, 3);
    send(station_addr, 6);
    chk("R9 restart mid-address", 5'b11100);
    send(48'h0000_0000_0099, 1);
    chk("R9 in_first clears result", 5'b00000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_broadcast();
    t_multicast();
    t_promisc();
    t_zero_cfg();
    t_stream();
    t_restart();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule